// File: doc/BRIEF.md
# Hysteretic digital PLL lock detector

This block sits beside a phase/frequency detector and decides whether the loop is locked. For every phase-detector cycle it counts fast-clock cycles between the reference strobe and the feedback strobe, whichever arrives first. It then rates the result as good, in-between or bad against two thresholds.

A run of consecutive good cycles raises an active-high lock flag. The run length is three cycles or five cycles, chosen by a mode bit. Once the flag is up, only a bad cycle clears it, so the gap between the two thresholds gives hysteresis. A phase cycle whose second edge fails to arrive within a timeout counts as bad.

Both strobes and the mode bit are synchronous to the fast clock, and each strobe is one cycle wide.

Top module: `lockdet_top`

## Requirements
- R1: `lock_o` is active high. It is 0 after a synchronous reset, and a reset also discards any partial run of good cycles.
- R2: The phase error is the number of fast-clock cycles from the first strobe of a cycle to the other strobe, in either order. Strobes in the same cycle give an error of 0. A cycle closes when both strobes have been seen, and `lock_o` reflects that cycle two clock edges after the closing strobe is sampled.
- R3: A cycle is good when its error is below ACQ_CYC (default 3; an error of exactly 3 is not good). With `mode_i` = 0, lock asserts on the third consecutive good cycle.
- R4: With `mode_i` = 1, lock asserts on the fifth consecutive good cycle, and not on the fourth.
- R5: While locked, a cycle with error above REL_CYC (default 5) deasserts lock. An error of at most REL_CYC leaves lock high.
- R6: While lock is being acquired, an error from ACQ_CYC to REL_CYC does not assert lock and restarts the run of good cycles.
- R7: If the second strobe has not arrived TIMEOUT_CYC (default 64) cycles after the first, the cycle is treated as bad. In that case lock drops at most two cycles later.
- R8: `mode_i` is sampled in the cycle where a run's first good result is taken. Later changes do not alter that run's length, and a mode change never clears an existing lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb_i | input | 1 | Reference edge strobe, one cycle wide |
| fb_stb_i | input | 1 | Feedback edge strobe, one cycle wide |
| mode_i | input | 1 | 0: three good cycles to lock, 1: five |
| lock_o | output | 1 | Lock flag, active high |

## Verification
Two events can meet in one cycle: the first good result of a new run being taken, and a change of the mode bit. The bench flips the mode in exactly the cycle where the opening good result is evaluated. It then judges which run length applied by counting how many good cycles pass before lock rises. It also flips the mode after a run has opened and confirms that the length chosen at the start still holds, and it checks that a mode change while locked leaves the flag high.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_WAIT_FB  = 2'd1,
        PH_WAIT_REF = 2'd2
    } ph_state_e;

    typedef enum logic [1:0] {
        V_GOOD = 2'd0,
        V_MID  = 2'd1,
        V_BAD  = 2'd2
    } verdict_e;

    typedef struct packed {
        logic     valid;
        verdict_e verdict;
    } ph_result_t;

    function automatic verdict_e classify(input int unsigned err,
                                          input int unsigned acq,
                                          input int unsigned rel);
        if (err < acq)      return V_GOOD;
        else if (err > rel) return V_BAD;
        else                return V_MID;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lockdet_phase_meas.sv
module lockdet_phase_meas
    import lockdet_pkg::*;
#(
    parameter int unsigned ACQ_CYC     = 3,
    parameter int unsigned REL_CYC     = 5,
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_stb_i,
    input  logic       fb_stb_i,
    output ph_result_t res_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 2);
    localparam logic [CNT_W-1:0] TMO = CNT_W'(TIMEOUT_CYC);

    ph_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, step;
    ph_result_t       res_n;
    logic             other;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        res_n   = '{valid: 1'b0, verdict: V_GOOD};
        step    = cnt_q + 1'b1;
        other   = (state_q == PH_WAIT_FB) ? fb_stb_i : ref_stb_i;
        case (state_q)
            PH_IDLE: begin
                cnt_n = '0;
                if (ref_stb_i && fb_stb_i) begin
                    res_n = '{valid: 1'b1, verdict: classify(0, ACQ_CYC, REL_CYC)};
                end else if (ref_stb_i) begin
                    state_n = PH_WAIT_FB;
                end else if (fb_stb_i) begin
                    state_n = PH_WAIT_REF;
                end
            end
            PH_WAIT_FB, PH_WAIT_REF: begin
                if (other) begin
                    res_n   = '{valid: 1'b1, verdict: classify(32'(step), ACQ_CYC, REL_CYC)};
                    state_n = PH_IDLE;
                    cnt_n   = '0;
                end else if (step >= TMO) begin
                    res_n   = '{valid: 1'b1, verdict: V_BAD};
                    state_n = PH_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = step;
                end
            end
            default: begin
                state_n = PH_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            res_o   <= '{valid: 1'b0, verdict: V_GOOD};
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            res_o   <= res_n;
        end
    end

    // R7: a pending phase cycle never counts past the timeout
    p_wait_below_timeout_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_IDLE) |-> (cnt_q < TMO));

    // R7: the last waiting cycle without the partner edge ends in a bad result
    p_timeout_is_bad_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_IDLE && step >= TMO && !other)
        |=> (res_o.valid && res_o.verdict == V_BAD && state_q == PH_IDLE));

endmodule

// File: rtl/lockdet_run_ctr.sv
module lockdet_run_ctr
    import lockdet_pkg::*;
#(
    parameter int unsigned NEED_LO = 3,
    parameter int unsigned NEED_HI = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  ph_result_t res_i,
    output logic       lock_o
);
    localparam int unsigned NMAX  = max_u(NEED_LO, NEED_HI);
    localparam int unsigned RUN_W = $clog2(NMAX + 1);
    localparam logic [RUN_W-1:0] N_LO = RUN_W'(NEED_LO);
    localparam logic [RUN_W-1:0] N_HI = RUN_W'(NEED_HI);

    logic [RUN_W-1:0] run_q, run_n, tgt_q, tgt_n, need_now, lim;
    logic             lock_n;

    always_comb begin
        need_now = mode_i ? N_HI : N_LO;
        lim      = (run_q == '0) ? need_now : tgt_q;
        run_n    = run_q;
        tgt_n    = tgt_q;
        lock_n   = lock_o;
        if (res_i.valid) begin
            if (!lock_o) begin
                if (res_i.verdict == V_GOOD) begin
                    if (run_q == '0) tgt_n = need_now;
                    if ((run_q + 1'b1) >= lim) begin
                        lock_n = 1'b1;
                        run_n  = '0;
                    end else begin
                        run_n = run_q + 1'b1;
                    end
                end else begin
                    run_n = '0;
                end
            end else if (res_i.verdict == V_BAD) begin
                lock_n = 1'b0;
                run_n  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            tgt_q  <= N_LO;
            lock_o <= 1'b0;
        end else begin
            run_q  <= run_n;
            tgt_q  <= tgt_n;
            lock_o <= lock_n;
        end
    end

    // R1: reset leaves the detector unlocked with an empty run
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!lock_o && run_q == '0));

    // R3: lock only rises on a good phase result
    p_rise_on_good_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(res_i.valid && res_i.verdict == V_GOOD));

    // R5: lock only falls on a bad phase result
    p_fall_on_bad_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_o) |-> $past(res_i.valid && res_i.verdict == V_BAD));

    // R6: an in-between error while unlocked empties the run
    p_mid_restarts_r6: assert property (@(posedge clk) disable iff (rst)
        (res_i.valid && res_i.verdict == V_MID && !lock_o) |=> (run_q == '0 && !lock_o));

    // R8: a mode change alone never clears lock
    p_mode_keeps_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (lock_o && !(res_i.valid && res_i.verdict == V_BAD)) |=> lock_o);

    // R4: the run never reaches the larger lock count
    p_run_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        run_q < RUN_W'(NMAX));

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int unsigned ACQ_CYC     = 3,
    parameter int unsigned REL_CYC     = 5,
    parameter int unsigned TIMEOUT_CYC = 64,
    parameter int unsigned NEED_LO     = 3,
    parameter int unsigned NEED_HI     = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_stb_i,
    input  logic fb_stb_i,
    input  logic mode_i,
    output logic lock_o
);
    ph_result_t res;

    lockdet_phase_meas #(
        .ACQ_CYC(ACQ_CYC), .REL_CYC(REL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) meas_i (
        .clk(clk), .rst(rst), .ref_stb_i(ref_stb_i), .fb_stb_i(fb_stb_i), .res_o(res)
    );

    lockdet_run_ctr #(
        .NEED_LO(NEED_LO), .NEED_HI(NEED_HI)
    ) run_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .res_i(res), .lock_o(lock_o)
    );

    // R2: a closed phase cycle is the only thing that can move lock
    p_lock_moves_on_result_r2: assert property (@(posedge clk) disable iff (rst)
        (lock_o != $past(lock_o)) |-> $past(res.valid));

endmodule

// File: tb/lockdet_top_tb_top.sv
module lockdet_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_stb = 1'b0;
    logic fb_stb = 1'b0;
    logic mode = 1'b0;
    logic lock;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockdet_top #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst(rst), .ref_stb_i(ref_stb), .fb_stb_i(fb_stb),
        .mode_i(mode), .lock_o(lock)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: lock actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // k >= 0: reference leads by k cycles; k < 0: feedback leads by -k cycles
    task automatic pd_cycle(input int k);
        int a;
        a = (k < 0) ? -k : k;
        @(negedge clk);
        if (k == 0) begin ref_stb = 1'b1; fb_stb = 1'b1; end
        else if (k > 0) ref_stb = 1'b1;
        else fb_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0; fb_stb = 1'b0;
        if (a != 0) begin
            repeat (a - 1) @(negedge clk);
            if (k > 0) fb_stb = 1'b1; else ref_stb = 1'b1;
            @(negedge clk);
            ref_stb = 1'b0; fb_stb = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(lock, 1'b0, "R1 reset state");
    endtask

    task automatic t_mode0_lock();
        do_reset(); mode = 1'b0;
        pd_cycle(1); pd_cycle(2);
        chk(lock, 1'b0, "R3 two good cycles");
        pd_cycle(0);
        chk(lock, 1'b1, "R3 third good cycle (same-cycle edges, R2)");
    endtask

    task automatic t_threshold_edge();
        do_reset(); mode = 1'b0;
        pd_cycle(2); pd_cycle(2); pd_cycle(3);
        chk(lock, 1'b0, "R3 error equal to acquire threshold is not good");
    endtask

    task automatic t_hysteresis();
        do_reset(); mode = 1'b0;
        pd_cycle(1); pd_cycle(1); pd_cycle(1);
        chk(lock, 1'b1, "R5 locked before release test");
        pd_cycle(4);
        chk(lock, 1'b1, "R5 in-between error keeps lock");
        pd_cycle(-5);
        chk(lock, 1'b1, "R5 error equal to release threshold keeps lock");
        pd_cycle(6);
        chk(lock, 1'b0, "R5 error above release threshold drops lock");
    endtask

    task automatic t_mid_breaks_run();
        do_reset(); mode = 1'b0;
        pd_cycle(1); pd_cycle(1); pd_cycle(4); pd_cycle(1); pd_cycle(1);
        chk(lock, 1'b0, "R6 in-between error restarts run");
        pd_cycle(-2);
        chk(lock, 1'b1, "R6 lock after fresh run of three (feedback leading, R2)");
    endtask

    task automatic t_mode1_lock();
        do_reset(); mode = 1'b1;
        pd_cycle(1); pd_cycle(1); pd_cycle(-1); pd_cycle(2);
        chk(lock, 1'b0, "R4 four good cycles in five-count mode");
        pd_cycle(0);
        chk(lock, 1'b1, "R4 fifth good cycle locks");
        mode = 1'b0;
        pd_cycle(1);
        chk(lock, 1'b1, "R8 mode change keeps lock");
        pd_cycle(-7);
        chk(lock, 1'b0, "R5 large error with feedback leading drops lock");
    endtask

    task automatic t_mode_at_run_start();
        do_reset(); mode = 1'b1;
        @(negedge clk);
        ref_stb = 1'b1; fb_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0; fb_stb = 1'b0;
        mode = 1'b0;
        repeat (2) @(negedge clk);
        pd_cycle(1);
        chk(lock, 1'b0, "R8 two good after coincident mode flip");
        pd_cycle(1);
        chk(lock, 1'b1, "R8 mode flipped at run start sets three-count run");
        do_reset(); mode = 1'b0;
        pd_cycle(1);
        mode = 1'b1;
        pd_cycle(1); pd_cycle(1);
        chk(lock, 1'b1, "R8 mode flip after run start does not lengthen run");
    endtask

    task automatic t_timeout();
        do_reset(); mode = 1'b0;
        pd_cycle(1); pd_cycle(1); pd_cycle(1);
        chk(lock, 1'b1, "R7 locked before timeout");
        @(negedge clk); ref_stb = 1'b1;
        @(negedge clk); ref_stb = 1'b0;
        repeat (TMO - 3) @(negedge clk);
        chk(lock, 1'b1, "R7 still locked before timeout expires");
        repeat (6) @(negedge clk);
        chk(lock, 1'b0, "R7 missing feedback edge drops lock");
    endtask

    task automatic t_reset_mid_run();
        do_reset(); mode = 1'b0;
        pd_cycle(1); pd_cycle(1);
        do_reset();
        pd_cycle(1); pd_cycle(1);
        chk(lock, 1'b0, "R1 reset discards partial run");
        pd_cycle(1);
        chk(lock, 1'b1, "R1 lock after full run following reset");
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        t_reset_state();
        t_mode0_lock();
        t_threshold_edge();
        t_hysteresis();
        t_mid_breaks_run();
        t_mode1_lock();
        t_mode_at_run_start();
        t_timeout();
        t_reset_mid_run();
        finished = 1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            report();
            $finish;
        end
    end

endmodule